// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block turns frames arriving on an asynchronous serial line into parallel words. The line idles high. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop bit. The word width, the parity mode and a parity-inclusive length option are chosen by configuration inputs. A one-clock enable pulse supplies timing at sixteen times the bit rate. The configuration is captured when each start edge is seen, so a change takes effect on the next frame.

The received parity bit is not stripped. It is returned in the output word at the bit just above the data bits, and a consumer that wants only data masks it off. Each word comes with a parity-error flag and a framing-error flag. The receiver takes frames that end with one or two stop bits, whatever the transmitter's stop setting is. After the first stop bit it hunts for the next start edge, so a second stop bit is simply idle line.

Results leave through a valid/ready port. A finished word is held, and `rx_valid` stays high until a cycle with `rx_ready` high. The serial line cannot be stalled, so back-pressure cannot slow the line. If a new frame finishes while a word is still held, the new word replaces it and `rx_valid` stays high. `rx_ready` therefore only decides when a held word is released.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_word` is all zeros, and both error flags are 0.
- R2: A high-to-low transition on the synchronized line starts a frame. The line is sampled again 8 ticks later. If it is high at that point, the edge is a glitch, the receiver returns to idle, and no word is produced.
- R3: `cfg_len` selects the number of data bits: 00=5, 01=6, 10=7, 11=8. Data bits arrive LSB first. Bit k of the frame lands in `rx_word[k]`. Each bit is sampled 16 ticks after the previous sample point.
- R4: `cfg_parity` selects the parity mode: 00=none, 01=even, 10=odd, 11=none. With parity enabled, the received parity bit is placed in `rx_word` at the index equal to the data-bit count. All bits above the data and parity bits are 0.
- R5: `rx_par_err` is 1 when parity is enabled and the ones count over data plus parity is odd in even mode or even in odd mode. It is always 0 when parity is none.
- R6: With `cfg_incl` = 1 and parity enabled, the parity bit counts toward the `cfg_len` length. The data-bit count is then one fewer, for example 7 data bits in bits 0 to 6 and parity in bit 7. With parity none, `cfg_incl` has no effect.
- R7: A low level at the stop-bit sample point sets `rx_frame_err`. The received word is still delivered.
- R8: Frames separated by one stop bit or by two stop bits are both received correctly.
- R9: A word becomes valid after the midpoint of its first stop bit and before that stop bit ends. `rx_valid` never rises without a completed frame.
- R10: While `rx_valid`=1 and `rx_ready`=0, the word and flags stay stable unless a newer frame completes. The newer frame replaces them and valid stays high. A cycle with both high clears `rx_valid` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Frame length code (5 to 8 bits) |
| cfg_parity | input | 2 | Parity mode code |
| cfg_incl | input | 1 | Parity counted within the length code |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer accepts the word |
| rx_word | output | 9 | Data bits with the parity bit just above them |
| rx_par_err | output | 1 | Parity mismatch for this word |
| rx_frame_err | output | 1 | Stop bit sampled low for this word |

## Verification
The only timed result is the word. It is due inside a known window: after the midpoint of the first stop bit (8 ticks in, plus up to three clocks of synchronizer lag and one tick period of edge-to-tick phase), and before that stop bit ends 16 ticks after it starts. The bench pushes its expected word into a queue when it starts driving the stop bit. It compares on every falling clock edge whenever a handshake occurs, and it requires the queue to be empty at the moment the stop bit ends. Any valid with an empty queue is an error. The hold behaviour is checked one clock after each change of `rx_ready`.

// File: rtl/serial_frame_rx_pkg.sv
package serial_frame_rx_pkg;

  localparam int unsigned WORD_W   = 9;
  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned OSR      = 16;
  localparam int unsigned IDX_W    = $clog2(WORD_W + 1);
  localparam int unsigned CNT_W    = $clog2(OSR);

  typedef enum logic [1:0] {
    PM_NONE  = 2'b00,
    PM_EVEN  = 2'b01,
    PM_ODD   = 2'b10,
    PM_NONE3 = 2'b11
  } par_mode_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP
  } rx_state_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              perr;
    logic              ferr;
  } rx_result_t;

endpackage

// File: rtl/serial_frame_rx_sync.sv
module serial_frame_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);

  logic [STAGES:0] chain;
  logic            prev;

  assign chain[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g+1] <= 1'b1;
      else        chain[g+1] <= chain[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES];
  end

  assign dout = chain[STAGES];
  assign fall = prev & ~chain[STAGES];

endmodule

// File: rtl/serial_frame_rx_core.sv
module serial_frame_rx_core
  import serial_frame_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = OSR,
  parameter int unsigned BASE_BITS  = MIN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              line,
  input  logic              fall,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_incl,
  output logic              done,
  output rx_result_t        result
);

  localparam int unsigned CW       = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE/2 - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(OVERSAMPLE - 1);

  rx_state_t         state;
  logic [CW-1:0]     tcnt;
  logic [IDX_W-1:0]  bidx;
  logic [IDX_W-1:0]  nd_q;
  logic              par_on_q;
  logic              odd_q;
  logic [WORD_W-1:0] shreg;
  logic              acc;
  logic              perr_q;

  par_mode_t         pmode;
  logic              par_on_cfg;
  logic [IDX_W-1:0]  nd_next;
  logic              mid_hit;
  logic              full_hit;

  assign pmode      = par_mode_t'(cfg_parity);
  assign par_on_cfg = (pmode == PM_EVEN) || (pmode == PM_ODD);
  assign nd_next    = IDX_W'(BASE_BITS) + IDX_W'(cfg_len)
                    - IDX_W'(cfg_incl & par_on_cfg);
  assign mid_hit    = os_tick && (tcnt == MID_CNT);
  assign full_hit   = os_tick && (tcnt == FULL_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RS_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      nd_q     <= IDX_W'(BASE_BITS);
      par_on_q <= 1'b0;
      odd_q    <= 1'b0;
      shreg    <= '0;
      acc      <= 1'b0;
      perr_q   <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        RS_IDLE: begin
          tcnt <= '0;
          if (fall) begin
            state    <= RS_START;
            nd_q     <= nd_next;
            par_on_q <= par_on_cfg;
            odd_q    <= (pmode == PM_ODD);
            bidx     <= '0;
            shreg    <= '0;
            acc      <= 1'b0;
            perr_q   <= 1'b0;
          end
        end
        RS_START: begin
          if (mid_hit) begin
            tcnt  <= '0;
            state <= line ? RS_IDLE : RS_DATA;
          end else if (os_tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RS_DATA: begin
          if (full_hit) begin
            tcnt        <= '0;
            shreg[bidx] <= line;
            acc         <= acc ^ line;
            bidx        <= bidx + 1'b1;
            if (bidx == nd_q - 1'b1) state <= par_on_q ? RS_PAR : RS_STOP;
          end else if (os_tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RS_PAR: begin
          if (full_hit) begin
            tcnt        <= '0;
            shreg[nd_q] <= line;
            perr_q      <= acc ^ line ^ odd_q;
            state       <= RS_STOP;
          end else if (os_tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RS_STOP: begin
          if (full_hit) begin
            tcnt        <= '0;
            done        <= 1'b1;
            result.word <= shreg;
            result.perr <= perr_q;
            result.ferr <= ~line;
            state       <= RS_IDLE;
          end else if (os_tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  // R2: a high line at the start midpoint aborts without output
  p_glitch_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_START && mid_hit && line) |=> (state == RS_IDLE && !done));

  // R7: framing flag mirrors the stop sample
  p_stop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_STOP && full_hit) |=> (done && result.ferr == !$past(line)));

  // R9: completion is a single-cycle event
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: short frames without parity leave the top bits clear
  p_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !par_on_q && nd_q < IDX_W'(8)) |-> (result.word[8:7] == 2'b00));

  // R5: no parity mode never reports a parity error
  p_no_par_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !par_on_q) |-> !result.perr);

endmodule

// File: rtl/serial_frame_rx_hold.sv
module serial_frame_rx_hold
  import serial_frame_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  rx_result_t din,
  input  logic       ready,
  output logic       valid,
  output rx_result_t dout
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R10: held word is stable under back-pressure
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(dout)));

  // R10: accepted word is released
  p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);

  // R9: a completed frame always surfaces
  p_load_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import serial_frame_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVERSAMPLE  = OSR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_incl,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_par_err,
  output logic              rx_frame_err
);

  logic       line_s;
  logic       fall_s;
  logic       done;
  rx_result_t res_core;
  rx_result_t res_hold;

  serial_frame_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s),
    .fall (fall_s)
  );

  serial_frame_rx_core #(.OVERSAMPLE(OVERSAMPLE), .BASE_BITS(MIN_BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .line      (line_s),
    .fall      (fall_s),
    .cfg_len   (cfg_len),
    .cfg_parity(cfg_parity),
    .cfg_incl  (cfg_incl),
    .done      (done),
    .result    (res_core)
  );

  serial_frame_rx_hold u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (done),
    .din  (res_core),
    .ready(rx_ready),
    .valid(rx_valid),
    .dout (res_hold)
  );

  assign rx_word      = res_hold.word;
  assign rx_par_err   = res_hold.perr;
  assign rx_frame_err = res_hold.ferr;

endmodule

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic [1:0] cfg_parity = 2'b00;
  logic       cfg_incl = 1'b0;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic [8:0] rx_word;
  logic       rx_par_err;
  logic       rx_frame_err;

  int errors = 0;
  int checks = 0;
  int pops = 0;
  bit mon_on = 1'b1;
  bit done_all = 1'b0;

  int    qw[$];
  bit    qp[$];
  bit    qf[$];
  string qt[$];

  int    last_w;
  bit    last_p;
  bit    last_f;

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV-1);
  end

  serial_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_incl(cfg_incl),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word),
    .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the expectation queue
  always @(negedge clk) begin
    if (rst_n && mon_on && rx_valid && rx_ready) begin
      pops++;
      if (qw.size() == 0) begin
        check(1'b0, "R9", "valid without frame", rx_word, 0);
      end else begin
        string t;
        int ew;
        bit ep, ef;
        ew = qw.pop_front(); ep = qp.pop_front(); ef = qf.pop_front();
        t = qt.pop_front();
        check(rx_word == 9'(ew), t, "word", rx_word, ew);
        check(rx_par_err == ep, "R5", "parity flag", rx_par_err, ep);
        check(rx_frame_err == ef, "R7", "framing flag", rx_frame_err, ef);
      end
    end
  end

  task automatic bit_time();
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                            input logic [1:0] par, input bit incl,
                            input bit flip, input bit stop_lvl,
                            input int nstop, input string tag);
    bit pon, xr, pbit;
    int nd;
    logic [7:0] dm;
    int w;
    pon = (par == 2'b01) || (par == 2'b10);
    nd = 5 + int'(len) - ((incl && pon) ? 1 : 0);
    dm = d & 8'((1 << nd) - 1);
    xr = ^dm;
    pbit = (par == 2'b10) ? ~xr : xr;
    if (flip) pbit = ~pbit;
    w = int'(dm) | (pon ? (int'(pbit) << nd) : 0);
    @(negedge clk);
    cfg_len = len; cfg_parity = par; cfg_incl = incl;
    rx_line = 1'b0;
    bit_time();
    for (int i = 0; i < nd; i++) begin
      rx_line = dm[i];
      bit_time();
    end
    if (pon) begin
      rx_line = pbit;
      bit_time();
    end
    last_w = w; last_p = flip && pon; last_f = !stop_lvl;
    if (mon_on) begin
      qw.push_back(w); qp.push_back(flip && pon); qf.push_back(!stop_lvl);
      qt.push_back(tag);
    end
    rx_line = stop_lvl;
    bit_time();
    if (mon_on) check(qw.size() == 0, "R9", "word due by stop end", qw.size(), 0);
    rx_line = 1'b1;
    if (nstop == 2 || !stop_lvl) bit_time();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done_all) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rx_valid == 1'b0, "R1", "valid after reset", rx_valid, 0);
    check(rx_word == 9'd0, "R1", "word after reset", rx_word, 0);
    check(rx_par_err == 1'b0 && rx_frame_err == 1'b0, "R1", "flags after reset",
          {rx_par_err, rx_frame_err}, 0);
    bit_time();

    // R3 lengths, no parity
    send_frame(8'hA5, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1, "R3 8N");
    send_frame(8'h13, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1, "R3 5N");
    send_frame(8'h2C, 2'b01, 2'b11, 1'b0, 1'b0, 1'b1, 1, "R4 6 code11");
    // R4 parity modes
    send_frame(8'hC3, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1, 1, "R4 8E");
    send_frame(8'h81, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 1, "R4 8O");
    send_frame(8'h55, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1, "R4 7O");
    send_frame(8'h3E, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1, "R4 6E");
    // R5 parity errors
    send_frame(8'h96, 2'b11, 2'b01, 1'b0, 1'b1, 1'b1, 1, "R5 8E bad");
    send_frame(8'h0F, 2'b00, 2'b10, 1'b0, 1'b1, 1'b1, 1, "R5 5O bad");
    // R6 parity-inclusive length
    send_frame(8'hFB, 2'b11, 2'b01, 1'b1, 1'b0, 1'b1, 1, "R6 incl 8E");
    send_frame(8'h6A, 2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1, "R6 incl 7O");
    send_frame(8'hE7, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 1, "R6 incl no par");
    // R7 framing error
    send_frame(8'h5A, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1, "R7 low stop");
    // R8 two stop bits, then back-to-back single stop
    send_frame(8'h01, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1, 2, "R8 two stop");
    send_frame(8'h80, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1, 2, "R8 two stop b");
    send_frame(8'hFF, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1, "R8 one stop a");
    send_frame(8'h00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1, "R8 one stop b");
    bit_time();

    // R2 glitch rejection
    p0 = pops;
    rx_line = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (3) bit_time();
    check(pops == p0 && !rx_valid, "R2", "glitch output", pops - p0, 0);
    send_frame(8'h6C, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1, "R2 after glitch");
    bit_time();

    // R10 back-pressure
    mon_on = 1'b0;
    rx_ready = 1'b0;
    send_frame(8'h3C, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1, "R10 a");
    check(rx_valid == 1'b1, "R10", "valid held", rx_valid, 1);
    check(rx_word == 9'(last_w), "R10", "word held", rx_word, last_w);
    repeat (50) @(negedge clk);
    check(rx_valid == 1'b1 && rx_word == 9'(last_w), "R10", "still held",
          rx_word, last_w);
    send_frame(8'hC1, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 1, "R10 b");
    check(rx_valid == 1'b1, "R10", "valid after replace", rx_valid, 1);
    check(rx_word == 9'(last_w), "R10", "newest word", rx_word, last_w);
    rx_ready = 1'b1;
    @(negedge clk);
    check(rx_valid == 1'b0, "R10", "cleared after take", rx_valid, 0);
    mon_on = 1'b1;
    bit_time();
    check(qw.size() == 0, "R9", "no leftover expectations", qw.size(), 0);

    done_all = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule